// File: doc/BRIEF.md
# Fast-Interrupt Source Selector

This block picks one of a set of raw, level-sensitive interrupt lines and sends it to a dedicated fast-interrupt output. Three banks of lines come in: a small basic bank (8 lines by default) and two wide peripheral banks (32 lines each). One 8-bit control word sets which line is routed and whether routing is on. While routing is on, the output simply follows the chosen raw line. It ignores whatever the normal interrupt masking does for that line.

The control word sits at one byte offset (0x0C by default) on a simple register port. A write with select and write-enable high at that offset loads the word on the next clock edge. A read at that offset returns the word zero-extended. The source index uses a flat numbering. The first wide bank comes first, then the second wide bank, and the basic bank comes last. Software that routes a line to the fast output should first mask that line in the normal path. Otherwise both handlers run for the same event.

Top module: `fiq_source_select`

## Requirements
- R1: After reset the control word is 0, the fast output is low, and a read at the control offset returns 0.
- R2: A write with `reg_sel` and `reg_we` high at the control offset stores `reg_wdata[7:0]` at the next rising clock edge. Bits [6:0] are the source index and bit 7 is the enable. Reading the offset then returns that byte, with bits 31:8 as 0.
- R3: Writes to any other offset leave the control word unchanged. Reads at any other offset return 0.
- R4: Index values 0 to 31 select line `irq_bank1[index]`.
- R5: Index values 32 to 63 select line `irq_bank2[index-32]`.
- R6: Index values 64 to 71 select line `irq_bank0[index-64]`.
- R7: Index values 72 to 127 select no line, and the fast output stays low whatever the raw lines do.
- R8: With the enable bit clear, the fast output stays low whatever the index and the raw lines are.
- R9: With routing on, the fast output equals the selected raw line in the same cycle. Lines that are not selected have no effect on it.
- R10: Writing 0 to the control offset turns the fast output off from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_bank0 | input | 8 | Basic-bank raw level lines (flat indices 64..71) |
| irq_bank1 | input | 32 | First wide-bank raw lines (flat indices 0..31) |
| irq_bank2 | input | 32 | Second wide-bank raw lines (flat indices 32..63) |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write enable, qualified by `reg_sel` |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fiq_out | output | 1 | Fast-interrupt output |

## Verification
A control write takes effect one clock edge after it is presented. The bench drives each write on a falling edge, lets one rising edge pass, and samples readback and the output on the next falling edge. The raw lines reach the output with no register in the path. After changing them, the bench waits one time unit inside the same low clock phase and then compares. Reads are combinational, so they are checked in the same phase in which the address is applied.

// File: rtl/fiq_sel_pkg.sv
package fiq_sel_pkg;
  // Control word layout: the index in the low bits, the enable above them.
  localparam int IDX_W  = 7;
  localparam int CTRL_W = IDX_W + 1;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } fiq_ctrl_t;

  // True when an index names one of the total_lines flat sources.
  function automatic logic idx_in_range(input logic [IDX_W-1:0] idx,
                                        input int unsigned total_lines);
    return (int'(idx) < int'(total_lines));
  endfunction

  // Zero-extends the control word onto the read bus.
  function automatic logic [31:0] ctrl_to_word(input fiq_ctrl_t c);
    return {{(32-CTRL_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/fiq_ctrl_reg.sv
module fiq_ctrl_reg
  import fiq_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  fiq_ctrl_t wr_val,
  output fiq_ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= wr_val;
  end
endmodule

// File: rtl/fiq_src_mux.sv
module fiq_src_mux
  import fiq_sel_pkg::*;
#(
  parameter int TOTAL = 72
) (
  input  logic [TOTAL-1:0] flat_src,
  input  logic [IDX_W-1:0] idx,
  output logic             sel_valid,
  output logic             sel_line
);
  logic [TOTAL-1:0] hit;

  // One comparator per source; an index beyond TOTAL matches none.
  for (genvar i = 0; i < TOTAL; i++) begin : g_hit
    assign hit[i] = (idx == IDX_W'(i)) & flat_src[i];
  end

  assign sel_line  = |hit;
  assign sel_valid = idx_in_range(idx, TOTAL);
endmodule

// File: rtl/fiq_source_select.sv
module fiq_source_select
  import fiq_sel_pkg::*;
#(
  parameter int        B0_W        = 8,
  parameter int        B1_W        = 32,
  parameter int        B2_W        = 32,
  parameter int        ADDR_W      = 8,
  parameter int        DATA_W      = 32,
  parameter bit [7:0]  CTRL_OFFSET = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [B0_W-1:0]   irq_bank0,
  input  logic [B1_W-1:0]   irq_bank1,
  input  logic [B2_W-1:0]   irq_bank2,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fiq_out
);
  localparam int TOTAL = B0_W + B1_W + B2_W;

  logic             addr_hit;
  logic             wr_hit;
  fiq_ctrl_t        ctrl_q;
  logic [TOTAL-1:0] flat_src;
  logic             sel_valid;
  logic             sel_line;
  logic [31:0]      ctrl_word;

  assign addr_hit = (reg_addr == ADDR_W'(CTRL_OFFSET));
  assign wr_hit   = reg_sel & reg_we & addr_hit;

  fiq_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wr_val (fiq_ctrl_t'(reg_wdata[CTRL_W-1:0])),
    .ctrl_q (ctrl_q)
  );

  // Flat order: first wide bank low, second wide bank next, basic bank last.
  assign flat_src = {irq_bank0, irq_bank2, irq_bank1};

  fiq_src_mux #(.TOTAL(TOTAL)) u_mux (
    .flat_src  (flat_src),
    .idx       (ctrl_q.idx),
    .sel_valid (sel_valid),
    .sel_line  (sel_line)
  );

  assign fiq_out   = ctrl_q.en & sel_line;
  assign ctrl_word = ctrl_to_word(ctrl_q);
  assign reg_rdata = addr_hit ? DATA_W'(ctrl_word) : '0;

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ctrl_q == $past(reg_wdata[CTRL_W-1:0])));

  assert_other_offset_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl_q));

  assert_no_source_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> !fiq_out);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> !fiq_out);

  assert_zero_write_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && reg_wdata[CTRL_W-1:0] == '0) |=> !fiq_out);
endmodule

// File: tb/sim_fiq_source_select.sv
module sim_fiq_source_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  b0 = '0;
  logic [31:0] b1 = '0, b2 = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_ctrl = '0;

  always #10 clk = ~clk;

  fiq_source_select u0 (
    .clk(clk), .rst_n(rst_n), .irq_bank0(b0), .irq_bank1(b1), .irq_bank2(b2),
    .reg_sel(sel), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .fiq_out(fiq)
  );

  function automatic logic exp_fiq(input logic [7:0] c, input logic [7:0] x0,
                                   input logic [31:0] x1, input logic [31:0] x2);
    int n;
    n = int'(c[6:0]);
    if (!c[7])   return 1'b0;
    if (n < 32)  return x1[n];
    if (n < 64)  return x2[n-32];
    if (n < 72)  return x0[n-64];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; addr = 8'h0C;
    if (a == 8'h0C) m_ctrl = d[7:0];
  endtask

  task automatic lines(input logic [7:0] x0, input logic [31:0] x1, input logic [31:0] x2);
    b0 = x0; b1 = x1; b2 = x2;
    #1;
  endtask

  task automatic chk_fiq(input string req);
    chk(req, {31'b0, fiq}, {31'b0, exp_fiq(m_ctrl, b0, b1, b2)});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    addr = 8'h0C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata, 32'h0);
    lines(8'hFF, '1, '1);
    chk("R1 fiq", {31'b0, fiq}, 32'h0);

    wr(8'h0C, 32'hFFFF_FF85);
    chk("R2 readback", rdata, 32'h85);
    lines(8'h00, 32'h0000_0020, 32'h0);
    chk("R4 idx5 high", {31'b0, fiq}, 32'h1);
    lines(8'hFF, 32'hFFFF_FFDF, 32'hFFFF_FFFF);
    chk("R9 others ignored", {31'b0, fiq}, 32'h0);

    wr(8'h0C, 32'h80 | 32'd40);
    lines(8'h00, 32'h0, 32'h0000_0100);
    chk("R5 idx40 high", {31'b0, fiq}, 32'h1);
    lines(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FEFF);
    chk("R5 idx40 low", {31'b0, fiq}, 32'h0);

    wr(8'h0C, 32'h80 | 32'd70);
    lines(8'h40, 32'h0, 32'h0);
    chk("R6 idx70 high", {31'b0, fiq}, 32'h1);
    lines(8'hBF, '1, '1);
    chk("R6 idx70 low", {31'b0, fiq}, 32'h0);

    wr(8'h0C, 32'h80 | 32'd72);
    lines(8'hFF, '1, '1);
    chk("R7 idx72", {31'b0, fiq}, 32'h0);
    wr(8'h0C, 32'hFF);
    chk("R7 idx127", {31'b0, fiq}, 32'h0);

    wr(8'h0C, 32'h05);
    chk("R8 disabled", {31'b0, fiq}, 32'h0);

    wr(8'h0C, 32'h83);
    wr(8'h08, 32'h00);
    addr = 8'h0C; #1;
    chk("R3 other write ignored", rdata, 32'h83);
    lines(8'h00, 32'h8, 32'h0);
    chk("R3 fiq kept", {31'b0, fiq}, 32'h1);
    addr = 8'h10; #1;
    chk("R3 other read zero", rdata, 32'h0);
    addr = 8'h0C;

    wr(8'h0C, 32'h0);
    chk("R10 off", {31'b0, fiq}, 32'h0);
    chk("R10 readback", rdata, 32'h0);

    for (int k = 0; k < 400; k++) begin
      if ((k % 4) == 0) wr(8'h0C, $urandom());
      lines(8'($urandom()), $urandom(), $urandom());
      chk_fiq("R9 random");
      if ((k % 4) == 0) chk("R2 random readback", rdata, {24'b0, m_ctrl});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule